// File: doc/BRIEF.md
# Bit Test and Complement Unit

This unit performs the data half of a read-modify-write bit instruction on a 24-bit word. A request carries an operand word, a 5-bit bit index, the current 16-bit processor status value, and a flag. The flag says whether the instruction writes to the status register itself or to some other place.

For an ordinary destination, the unit copies the addressed bit, as it was before the change, into the carry flag (status bit 0). It then inverts that bit in the returned word. For the status register as destination, it inverts only the addressed status flag and leaves carry alone unless bit 0 was the target. The operand word then passes through unchanged.

Indexes that address nothing are flagged and change nothing. For an ordinary destination these are indexes 24 to 31. For the status register they are the reserved positions 7, 12 and 14, and any index of 16 or more. Results are registered and appear one clock after a valid request. The instruction decoder and the memory interface sit outside this unit.

Top module: `bit_toggle_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle in which `req_valid` was high. A synchronous active-high `rst` clears `res_valid`, `res_word`, `res_status` and `res_illegal` to zero.
- R2: For an ordinary destination (`req_to_status`=0) with `req_index` ≤ 23, `res_status[0]` (carry) equals bit `req_index` of `req_word` before inversion.
- R3: For an ordinary destination with `req_index` ≤ 23, `res_word` equals `req_word` with only bit `req_index` inverted.
- R4: For an ordinary destination, `res_status[15:1]` equals `req_status[15:1]`.
- R5: For an ordinary destination with `req_index` in 24..31, `res_word` equals `req_word`, `res_status` equals `req_status`, and `res_illegal` is 1.
- R6: For a status destination (`req_to_status`=1) with `req_index` in {0..6, 8..11, 13, 15}, `res_status` equals `req_status` with only bit `req_index` inverted. Bit 0 is carry, bit 15 is the loop flag.
- R7: For a status destination, `res_word` equals `req_word`.
- R8: For a status destination with `req_index` in {7, 12, 14} or ≥ 16, `res_status` equals `req_status` and `res_illegal` is 1.
- R9: For every request with an index that is legal for its destination, `res_illegal` is 0.
- R10: In a cycle after one with `req_valid` low, `res_word`, `res_status` and `res_illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_word | input | 24 | Operand word |
| req_index | input | 5 | Bit position to test and invert |
| req_to_status | input | 1 | 1: the destination is the status register |
| req_status | input | 16 | Current status register value |
| res_valid | output | 1 | Result present this cycle |
| res_word | output | 24 | Modified operand word |
| res_status | output | 16 | Updated status register value |
| res_illegal | output | 1 | Index addressed no legal bit; nothing changed |

## Verification
Every index from 0 to 31 is swept in both destination modes over all-zero, all-one and alternating operands. This separates a wrong bit position from a wrong polarity, and shows whether the carry takes the bit before or after inversion. The reserved status positions and the boundary indexes 15, 16, 23 and 24 are driven on purpose, to test the legality edges. A random phase then uses a fixed seed and mixes idle cycles with the requests. It compares against bench functions written with plain bit indexing, to catch leaks into untouched bits and results that change while no request is present.

// File: rtl/bit_toggle_pkg.sv
package bit_toggle_pkg;
  localparam int WORD_W = 24;
  localparam int STAT_W = 16;
  localparam int IDX_W  = 5;
  // Status positions that hold no flag
  localparam logic [STAT_W-1:0] STAT_RESERVED = 16'h5080;
  localparam int CARRY_POS = 0;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [STAT_W-1:0] status;
    logic              illegal;
  } bt_result_t;
endpackage

// File: rtl/bit_toggle_decode.sv
module bit_toggle_decode #(
  parameter int WORD_W = 24,
  parameter int STAT_W = 16,
  parameter int IDX_W  = 5,
  parameter logic [STAT_W-1:0] RESERVED = '0
) (
  input  logic [IDX_W-1:0]  index,
  output logic [WORD_W-1:0] word_mask,
  output logic [STAT_W-1:0] stat_mask,
  output logic              word_ok,
  output logic              stat_ok
);
  // One-hot position masks; all-zero when the index is out of range
  for (genvar i = 0; i < WORD_W; i++) begin : g_word
    assign word_mask[i] = (index == IDX_W'(i));
  end
  for (genvar j = 0; j < STAT_W; j++) begin : g_stat
    assign stat_mask[j] = (index == IDX_W'(j)) && !RESERVED[j];
  end

  assign word_ok = |word_mask;
  assign stat_ok = |stat_mask;
endmodule

// File: rtl/bit_toggle_word_path.sv
module bit_toggle_word_path #(
  parameter int WORD_W = 24
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] mask,
  input  logic              ok,
  input  logic              carry_in,
  output logic [WORD_W-1:0] word_out,
  output logic              carry_out
);
  logic picked;

  always_comb begin
    picked    = |(word_in & mask);
    word_out  = word_in ^ mask;
    carry_out = ok ? picked : carry_in;
  end
endmodule

// File: rtl/bit_toggle_status_path.sv
module bit_toggle_status_path #(
  parameter int STAT_W = 16
) (
  input  logic [STAT_W-1:0] status_in,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] status_out
);
  always_comb status_out = status_in ^ mask;
endmodule

// File: rtl/bit_toggle_unit.sv
module bit_toggle_unit
  import bit_toggle_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_word,
  input  logic [IDX_W-1:0]  req_index,
  input  logic              req_to_status,
  input  logic [STAT_W-1:0] req_status,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic [STAT_W-1:0] res_status,
  output logic              res_illegal
);
  logic [WORD_W-1:0] word_mask;
  logic [STAT_W-1:0] stat_mask;
  logic              word_ok, stat_ok;
  logic [WORD_W-1:0] word_mod;
  logic              carry_new;
  logic [STAT_W-1:0] stat_mod;
  bt_result_t        next_res, res_q;
  logic              valid_q;

  bit_toggle_decode #(
    .WORD_W(WORD_W), .STAT_W(STAT_W), .IDX_W(IDX_W), .RESERVED(STAT_RESERVED)
  ) u_decode (
    .index(req_index), .word_mask(word_mask), .stat_mask(stat_mask),
    .word_ok(word_ok), .stat_ok(stat_ok)
  );

  bit_toggle_word_path #(.WORD_W(WORD_W)) u_word (
    .word_in(req_word), .mask(word_mask), .ok(word_ok),
    .carry_in(req_status[CARRY_POS]), .word_out(word_mod), .carry_out(carry_new)
  );

  bit_toggle_status_path #(.STAT_W(STAT_W)) u_stat (
    .status_in(req_status), .mask(stat_mask), .status_out(stat_mod)
  );

  always_comb begin
    if (req_to_status) begin
      next_res.word    = req_word;
      next_res.status  = stat_mod;
      next_res.illegal = !stat_ok;
    end else begin
      next_res.word    = word_mod;
      next_res.status  = req_status;
      next_res.status[CARRY_POS] = carry_new;
      next_res.illegal = !word_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) res_q <= next_res;
    end
  end

  assign res_valid   = valid_q;
  assign res_word    = res_q.word;
  assign res_status  = res_q.status;
  assign res_illegal = res_q.illegal;
endmodule

// File: rtl/bit_toggle_unit_checker.sv
module bit_toggle_unit_checker
  import bit_toggle_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [WORD_W-1:0] req_word,
  input logic [IDX_W-1:0]  req_index,
  input logic              req_to_status,
  input logic [STAT_W-1:0] req_status,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_word,
  input logic [STAT_W-1:0] res_status,
  input logic              res_illegal
);
  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(req_valid)));

  assert_carry_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_to_status && req_index < 5'd24))
      |-> (res_status[0] == $past(req_word[req_index])));

  assert_single_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_to_status))
      |-> ($countones(res_word ^ $past(req_word)) <= 1));

  assert_upper_status_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_to_status))
      |-> (res_status[15:1] == $past(req_status[15:1])));

  assert_status_word_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_to_status))
      |-> (res_word == $past(req_word)));

  assert_status_single_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_to_status))
      |-> ($countones(res_status ^ $past(req_status)) <= 1));

  assert_illegal_no_change_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_to_status) && res_illegal)
      |-> (res_status == $past(req_status)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid))
      |-> ($stable(res_word) && $stable(res_status) && $stable(res_illegal)));
endmodule

bind bit_toggle_unit bit_toggle_unit_checker u_checker (.*);

// File: tb/bit_toggle_unit_test.sv
`timescale 1ns/1ps
module bit_toggle_unit_test;
  logic        clk = 0;
  logic        rst;
  logic        req_valid;
  logic [23:0] req_word;
  logic [4:0]  req_index;
  logic        req_to_status;
  logic [15:0] req_status;
  logic        res_valid;
  logic [23:0] res_word;
  logic [15:0] res_status;
  logic        res_illegal;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bit_toggle_unit uut (.*);

  function automatic bit legal_stat(input logic [4:0] i);
    return (i < 16) && (i != 7) && (i != 12) && (i != 14);
  endfunction

  function automatic logic [23:0] ref_word(input logic [23:0] w, input logic [4:0] i, input logic ts);
    logic [23:0] r = w;
    if (!ts && i < 24) r[i] = !w[i];
    return r;
  endfunction

  function automatic logic [15:0] ref_status(input logic [23:0] w, input logic [4:0] i,
                                             input logic ts, input logic [15:0] s);
    logic [15:0] r = s;
    if (ts) begin
      if (legal_stat(i)) r[i] = !s[i];
    end else if (i < 24) r[0] = w[i];
    return r;
  endfunction

  function automatic logic ref_illegal(input logic [4:0] i, input logic ts);
    return ts ? !legal_stat(i) : (i >= 24);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample at the following negedge (one register stage)
  task automatic run_one(input logic [23:0] w, input logic [4:0] i, input logic ts, input logic [15:0] s);
    req_valid = 1; req_word = w; req_index = i; req_to_status = ts; req_status = s;
    @(negedge clk);
    req_valid = 0;
    check("R1", {31'd0, res_valid}, 32'd1);
    if (ts) begin
      check("R7", {8'd0, res_word}, {8'd0, ref_word(w, i, ts)});
      check(legal_stat(i) ? "R6" : "R8", {16'd0, res_status}, {16'd0, ref_status(w, i, ts, s)});
      check(legal_stat(i) ? "R9" : "R8", {31'd0, res_illegal}, {31'd0, ref_illegal(i, ts)});
    end else if (i < 24) begin
      check("R3", {8'd0, res_word}, {8'd0, ref_word(w, i, ts)});
      check("R2", {31'd0, res_status[0]}, {31'd0, w[i]});
      check("R4", {17'd0, res_status[15:1]}, {17'd0, s[15:1]});
      check("R9", {31'd0, res_illegal}, 32'd0);
    end else begin
      check("R5", {8'd0, res_word}, {8'd0, w});
      check("R5", {16'd0, res_status}, {16'd0, s});
      check("R5", {31'd0, res_illegal}, 32'd1);
    end
  endtask

  task automatic idle_check(input logic [23:0] w, input logic [4:0] i, input logic ts, input logic [15:0] s);
    logic [23:0] pw = res_word;
    logic [15:0] ps = res_status;
    logic        pi = res_illegal;
    req_valid = 0; req_word = w; req_index = i; req_to_status = ts; req_status = s;
    @(negedge clk);
    check("R1", {31'd0, res_valid}, 32'd0);
    check("R10", {8'd0, res_word}, {8'd0, pw});
    check("R10", {16'd0, res_status}, {16'd0, ps});
    check("R10", {31'd0, res_illegal}, {31'd0, pi});
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    logic [23:0] pats [3] = '{24'h000000, 24'hFFFFFF, 24'hA5A5A5};
    rst = 1; req_valid = 0; req_word = 0; req_index = 0; req_to_status = 0; req_status = 0;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, res_valid}, 32'd0);
    check("R1", {8'd0, res_word}, 32'd0);
    check("R1", {16'd0, res_status}, 32'd0);
    check("R1", {31'd0, res_illegal}, 32'd0);
    rst = 0;
    @(negedge clk);
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 32; k++)
          run_one(pats[p], 5'(k), m[0], ~pats[p][15:0]);
    run_one(24'h000080, 5'd7, 1'b0, 16'h0001);
    run_one(24'h123456, 5'd0, 1'b1, 16'h0001);
    run_one(24'h123456, 5'd15, 1'b1, 16'h0000);
    run_one(24'h123456, 5'd14, 1'b1, 16'hFFFF);
    idle_check(24'hFFFFFF, 5'd3, 1'b0, 16'h0000);
    run_one(24'h800000, 5'd23, 1'b0, 16'h0000);
    run_one(24'h800000, 5'd24, 1'b0, 16'h7FFE);
    for (int n = 0; n < 600; n++) begin
      logic [23:0] w = 24'($urandom(seed));
      logic [4:0]  i = 5'($urandom);
      logic        ts = 1'($urandom);
      logic [15:0] s = 16'($urandom);
      if ($urandom % 4 == 0) idle_check(w, i, ts, s);
      else run_one(w, i, ts, s);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule